// File: doc/BRIEF.md
# Frame Sync One-Shot Strobe Generator

This block sits on the frame sync path of two channel pairs. For each pair it either passes the incoming frame sync straight to the output, optionally inverted, or replaces it with a one-shot strobe. In strobe mode every frame start arms the pair. The pair launches on a chosen edge of a shared bit clock and then emits exactly one pulse. The pulse lasts one full period of that pair's own timing reference input. One 32-bit control word, loaded through a simple write port, holds a strobe-enable bit and a polarity bit for each pair. A pair copies its fields into a working copy only at a frame start, so a new setting never breaks a frame that is already running.

Each pair runs a four-state machine. IDLE waits for a frame start. The transition *start* (a frame start while the loaded strobe bit is set) goes to ARMED. ARMED waits for the launch edge; the transition *launch* goes to WAIT_REF. WAIT_REF waits for a rising edge of the reference; the transition *open* goes to PULSE and drives the output to its active level. PULSE waits for the next reference rising edge; the transition *close* returns to IDLE. Outside IDLE, frame starts are ignored. All inputs are sampled on the system clock.

Top module: `fsync_strobe_gen`

## Requirements
- R1: A synchronous active-high reset clears the control word and both working copies and puts both machines in IDLE. With frame sync inputs low, both outputs are then low.
- R2: When a pair's loaded strobe bit (bit 0 for pair 0, bit 16 for pair 1) is clear and its polarity bit is clear, the pair's output equals its frame sync input in the same cycle.
- R3: When the loaded polarity bit (bit 1 for pair 0, bit 17 for pair 1) is set and the strobe bit is clear, the output is the inverse of the frame sync input.
- R4: With the strobe bit loaded and the polarity bit clear, the output is high for exactly one reference period. The pulse starts at the first reference rising edge after launch and ends at the next one (8 cycles for a reference of period 8, 12 cycles for period 12).
- R5: With both strobe and polarity bits loaded, the output rests high and the strobe is a low pulse of the same width as in R4.
- R6: Each frame start in strobe mode produces exactly one pulse, and this repeats on every later frame start.
- R7: A frame start that arrives while a pair is not in IDLE neither extends the pulse nor causes a second pulse.
- R8: Control bits other than 0, 1, 16 and 17 have no effect on any output.
- R9: A control write changes a pair's behaviour only from that pair's next frame start. Before then the output follows the previously loaded fields.
- R10: After a frame start, launch waits for a rising bit clock edge when polarity is clear and a falling edge when it is set. Without that edge, no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | New control word |
| bclk_in | input | 1 | Shared bit clock whose edges launch a strobe |
| frame_start | input | 2 | Per-pair frame start indication, one cycle high |
| fsync_in | input | 2 | Per-pair incoming frame sync |
| ref_in | input | 2 | Per-pair timing reference that sets the pulse width |
| fsync_out | output | 2 | Per-pair frame sync output |

## Verification
A control write lands on the next clock edge but stays invisible until a frame start. That frame start is captured on the following edge, so the changed output is checked one cycle after the frame start is removed. In pass-through mode the output is combinational from the input, so it is checked in the same cycle the input is driven. In strobe mode the pulse becomes visible in the cycle after the edge that samples the first qualifying reference rise. It stays active for exactly as many cycles as the reference period. The bench therefore counts active cycles and rising transitions over a window long enough to hold arming, launch and pulse. It samples 1 ns after each falling clock edge, and every input changes at that same point.

// File: rtl/fsync_strobe_pkg.sv
`timescale 1ns/1ps
package fsync_strobe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_WAIT_REF = 2'd2,
        ST_PULSE    = 2'd3
    } strobe_state_e;

    typedef struct packed {
        logic strobe;
        logic pol;
    } pair_cfg_t;

    localparam int FIELD_STROBE = 0;
    localparam int FIELD_POL    = 1;

endpackage

// File: rtl/fsync_ctrl_reg.sv
`timescale 1ns/1ps
module fsync_ctrl_reg #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

endmodule

// File: rtl/fsync_edge_det.sv
`timescale 1ns/1ps
module fsync_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] sig_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_d <= '0;
        end else begin
            sig_d <= sig;
        end
    end

    always_comb begin
        rise = sig & ~sig_d;
        fall = ~sig & sig_d;
    end

endmodule

// File: rtl/fsync_strobe_chan.sv
`timescale 1ns/1ps
module fsync_strobe_chan
    import fsync_strobe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          fsync_in,
    input  logic          ref_rise,
    input  logic          bclk_rise,
    input  logic          bclk_fall,
    input  pair_cfg_t     cfg_next,
    output logic          fsync_out,
    output strobe_state_e state_o,
    output pair_cfg_t     cfg_o
);

    strobe_state_e state_q;
    strobe_state_e state_d;
    pair_cfg_t     cfg_q;
    logic          launch_edge;
    logic          take_frame;

    assign take_frame  = frame_start && (state_q == ST_IDLE);
    assign launch_edge = cfg_q.pol ? bclk_fall : bclk_rise;

    // next-state selection: start, launch, open, close
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (take_frame && cfg_next.strobe) state_d = ST_ARMED;
            ST_ARMED:    if (launch_edge)                   state_d = ST_WAIT_REF;
            ST_WAIT_REF: if (ref_rise)                      state_d = ST_PULSE;
            ST_PULSE:    if (ref_rise)                      state_d = ST_IDLE;
            default:                                        state_d = ST_IDLE;
        endcase
    end

    // state register and working copy of the pair fields
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_frame) begin
                cfg_q <= cfg_next;
            end
        end
    end

    // output level
    always_comb begin
        logic pulse_on;
        pulse_on = (state_q == ST_PULSE);
        if (cfg_q.strobe) begin
            fsync_out = pulse_on ^ cfg_q.pol;
        end else begin
            fsync_out = fsync_in ^ cfg_q.pol;
        end
    end

    assign state_o = state_q;
    assign cfg_o   = cfg_q;

endmodule

// File: rtl/fsync_strobe_gen.sv
`timescale 1ns/1ps
module fsync_strobe_gen
    import fsync_strobe_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int NUM_PAIRS   = 2,
    parameter int PAIR_STRIDE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 bclk_in,
    input  logic [NUM_PAIRS-1:0] frame_start,
    input  logic [NUM_PAIRS-1:0] fsync_in,
    input  logic [NUM_PAIRS-1:0] ref_in,
    output logic [NUM_PAIRS-1:0] fsync_out
);

    localparam int FIELD_SPAN = NUM_PAIRS * PAIR_STRIDE;

    logic [REG_W-1:0]     ctrl_q;
    logic [NUM_PAIRS-1:0] ref_rise;
    logic [NUM_PAIRS-1:0] ref_fall;
    logic                 bclk_rise;
    logic                 bclk_fall;
    strobe_state_e        chan_state [NUM_PAIRS];
    pair_cfg_t            chan_cfg   [NUM_PAIRS];

    fsync_ctrl_reg #(.REG_W(REG_W)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    fsync_edge_det #(.W(1)) bclk_edge_i (
        .clk  (clk),
        .rst  (rst),
        .sig  (bclk_in),
        .rise (bclk_rise),
        .fall (bclk_fall)
    );

    fsync_edge_det #(.W(NUM_PAIRS)) ref_edge_i (
        .clk  (clk),
        .rst  (rst),
        .sig  (ref_in),
        .rise (ref_rise),
        .fall (ref_fall)
    );

    generate
        if (FIELD_SPAN > REG_W) begin : g_bad_span
            initial $display("fsync_strobe_gen: pair fields exceed control width");
        end
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
            pair_cfg_t field;
            assign field.strobe = ctrl_q[i*PAIR_STRIDE + FIELD_STROBE];
            assign field.pol    = ctrl_q[i*PAIR_STRIDE + FIELD_POL];

            fsync_strobe_chan chan_i (
                .clk         (clk),
                .rst         (rst),
                .frame_start (frame_start[i]),
                .fsync_in    (fsync_in[i]),
                .ref_rise    (ref_rise[i]),
                .bclk_rise   (bclk_rise),
                .bclk_fall   (bclk_fall),
                .cfg_next    (field),
                .fsync_out   (fsync_out[i]),
                .state_o     (chan_state[i]),
                .cfg_o       (chan_cfg[i])
            );
        end
    endgenerate

    logic unused_ok;
    assign unused_ok = ^ref_fall;

endmodule

// File: rtl/fsync_strobe_chk.sv
`timescale 1ns/1ps
module fsync_strobe_chk
    import fsync_strobe_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bclk_in,
    input logic [NUM_PAIRS-1:0] frame_start,
    input logic [NUM_PAIRS-1:0] ref_in,
    input logic [NUM_PAIRS-1:0] fsync_out,
    input strobe_state_e        chan_state [NUM_PAIRS],
    input pair_cfg_t            chan_cfg   [NUM_PAIRS]
);

    logic                 bclk_seen;
    logic [NUM_PAIRS-1:0] ref_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_seen <= 1'b0;
            ref_seen  <= '0;
        end else begin
            bclk_seen <= bclk_in;
            ref_seen  <= ref_in;
        end
    end

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_chk
        logic want_edge;
        logic ref_up;
        assign want_edge = chan_cfg[i].pol ? (bclk_seen && !bclk_in) : (!bclk_seen && bclk_in);
        assign ref_up    = ref_in[i] && !ref_seen[i];

        assert_reset_clear_R1: assert property (@(posedge clk)
            rst |=> (chan_state[i] == ST_IDLE && chan_cfg[i] == '0));

        assert_pass_stays_idle_R2: assert property (@(posedge clk) disable iff (rst)
            !chan_cfg[i].strobe |-> chan_state[i] == ST_IDLE);

        assert_pulse_level_R4: assert property (@(posedge clk) disable iff (rst)
            chan_state[i] == ST_PULSE |-> fsync_out[i] == !chan_cfg[i].pol);

        assert_close_on_ref_R4: assert property (@(posedge clk) disable iff (rst)
            (chan_state[i] == ST_PULSE && ref_up) |=> chan_state[i] == ST_IDLE);

        assert_hold_pulse_R4: assert property (@(posedge clk) disable iff (rst)
            (chan_state[i] == ST_PULSE && !ref_up) |=> chan_state[i] == ST_PULSE);

        assert_rest_level_R5: assert property (@(posedge clk) disable iff (rst)
            (chan_cfg[i].strobe && chan_state[i] != ST_PULSE) |-> fsync_out[i] == chan_cfg[i].pol);

        assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (rst)
            chan_state[i] != ST_IDLE |=> $stable(chan_cfg[i]));

        assert_load_at_frame_R9: assert property (@(posedge clk) disable iff (rst)
            !frame_start[i] |=> $stable(chan_cfg[i]));

        assert_launch_edge_R10: assert property (@(posedge clk) disable iff (rst)
            (chan_state[i] == ST_ARMED && !want_edge) |=> chan_state[i] == ST_ARMED);
    end

endmodule

bind fsync_strobe_gen fsync_strobe_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bclk_in     (bclk_in),
    .frame_start (frame_start),
    .ref_in      (ref_in),
    .fsync_out   (fsync_out),
    .chan_state  (chan_state),
    .chan_cfg    (chan_cfg)
);

// File: tb/fsync_strobe_gen_tb.sv
`timescale 1ns/1ps
module fsync_strobe_gen_tb_top;

    localparam int REF0_PERIOD = 8;
    localparam int REF1_PERIOD = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        bclk_in;
    logic [1:0]  frame_start = '0;
    logic [1:0]  fsync_in = '0;
    logic [1:0]  ref_in;
    logic [1:0]  fsync_out;

    logic bclk_auto = 1'b1;
    logic bclk_man  = 1'b0;
    logic bclk_gen  = 1'b0;
    int   bclk_cnt  = 0;
    int   ref0_cnt  = 0;
    int   ref1_cnt  = 0;
    int   tests     = 0;
    int   fails     = 0;
    logic done      = 1'b0;

    always #2.5 clk = ~clk;

    assign bclk_in   = bclk_auto ? bclk_gen : bclk_man;
    assign ref_in[0] = (ref0_cnt < REF0_PERIOD / 2);
    assign ref_in[1] = (ref1_cnt < REF1_PERIOD / 2);

    always @(negedge clk) begin
        ref0_cnt <= (ref0_cnt == REF0_PERIOD - 1) ? 0 : ref0_cnt + 1;
        ref1_cnt <= (ref1_cnt == REF1_PERIOD - 1) ? 0 : ref1_cnt + 1;
        bclk_cnt <= (bclk_cnt == 1) ? 0 : bclk_cnt + 1;
        if (bclk_cnt == 1) bclk_gen <= ~bclk_gen;
    end

    fsync_strobe_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .bclk_in     (bclk_in),
        .frame_start (frame_start),
        .fsync_in    (fsync_in),
        .ref_in      (ref_in),
        .fsync_out   (fsync_out)
    );

    task automatic check(input string req, input string what, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic write_ctrl(input logic [31:0] value);
        wr_en   = 1'b1;
        wr_data = value;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic fs_pulse(input logic [1:0] mask);
        frame_start = mask;
        tick();
        frame_start = '0;
    endtask

    task automatic run_window(input int n, input logic [1:0] pol, input logic retrig,
                              output int act0, output int act1,
                              output int rises0, output int rises1);
        logic [1:0] prev;
        logic [1:0] a;
        act0 = 0; act1 = 0; rises0 = 0; rises1 = 0;
        prev = fsync_out ^ pol;
        for (int k = 0; k < n; k++) begin
            tick();
            a = fsync_out ^ pol;
            if (a[0]) act0++;
            if (a[1]) act1++;
            if (a[0] && !prev[0]) rises0++;
            if (a[1] && !prev[1]) rises1++;
            frame_start[0] = retrig && a[0];
            prev = a;
        end
        frame_start = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1", "pair0 output after reset", fsync_out[0], 0);
        check("R1", "pair1 output after reset", fsync_out[1], 0);
    endtask

    task automatic t_passthru();
        write_ctrl(32'h0000_0000);
        fs_pulse(2'b11);
        fsync_in = 2'b01;
        #0.5;
        check("R2", "pass-through 01", fsync_out, 2'b01);
        fsync_in = 2'b10;
        #0.5;
        check("R2", "pass-through 10", fsync_out, 2'b10);
        tick();
    endtask

    task automatic t_polarity();
        write_ctrl(32'h0002_0002);
        fsync_in = 2'b01;
        #0.5;
        check("R9", "old polarity kept before frame start", fsync_out, 2'b01);
        tick();
        fs_pulse(2'b11);
        check("R3", "inverted pass-through 01", fsync_out, 2'b10);
        fsync_in = 2'b10;
        #0.5;
        check("R3", "inverted pass-through 10", fsync_out, 2'b01);
        tick();
    endtask

    task automatic t_reserved();
        write_ctrl(32'hFFFC_FFFC);
        fs_pulse(2'b11);
        fsync_in = 2'b01;
        #0.5;
        check("R8", "reserved bits leave pass-through", fsync_out, 2'b01);
        tick();
        fsync_in = 2'b00;
    endtask

    task automatic t_strobe_width();
        int a0, a1, r0, r1;
        write_ctrl(32'h0001_0001);
        fs_pulse(2'b11);
        run_window(40, 2'b00, 1'b0, a0, a1, r0, r1);
        check("R4", "pair0 width", a0, REF0_PERIOD);
        check("R4", "pair1 width", a1, REF1_PERIOD);
        check("R6", "pair0 pulse count", r0, 1);
        check("R6", "pair1 pulse count", r1, 1);
    endtask

    task automatic t_repeat();
        int a0, a1, r0, r1;
        for (int f = 0; f < 2; f++) begin
            fs_pulse(2'b11);
            run_window(40, 2'b00, 1'b0, a0, a1, r0, r1);
            check("R6", "pair0 pulses in frame", r0, 1);
            check("R6", "pair1 pulses in frame", r1, 1);
        end
    endtask

    task automatic t_active_low();
        int a0, a1, r0, r1;
        write_ctrl(32'h0003_0003);
        fs_pulse(2'b11);
        check("R5", "rest level high", fsync_out, 2'b11);
        run_window(40, 2'b11, 1'b0, a0, a1, r0, r1);
        check("R5", "pair0 low width", a0, REF0_PERIOD);
        check("R5", "pair1 low width", a1, REF1_PERIOD);
        check("R5", "pair0 low pulse count", r0, 1);
    endtask

    task automatic t_retrigger();
        int a0, a1, r0, r1;
        write_ctrl(32'h0000_0001);
        fs_pulse(2'b01);
        run_window(50, 2'b00, 1'b1, a0, a1, r0, r1);
        check("R7", "width with frame starts during pulse", a0, REF0_PERIOD);
        check("R7", "single pulse despite retrigger", r0, 1);
    endtask

    task automatic t_launch_edge();
        int a0, a1, r0, r1;
        bclk_man  = 1'b0;
        bclk_auto = 1'b0;
        tick();
        write_ctrl(32'h0000_0001);
        fs_pulse(2'b01);
        run_window(30, 2'b00, 1'b0, a0, a1, r0, r1);
        check("R10", "no pulse without rising bit clock", r0, 0);
        bclk_man = 1'b1;
        run_window(30, 2'b00, 1'b0, a0, a1, r0, r1);
        check("R10", "pulse after rising bit clock", r0, 1);
        write_ctrl(32'h0000_0003);
        bclk_man = 1'b0;
        tick();
        fs_pulse(2'b01);
        bclk_man = 1'b1;
        run_window(30, 2'b01, 1'b0, a0, a1, r0, r1);
        check("R10", "rising edge ignored with polarity set", r0, 0);
        bclk_man = 1'b0;
        run_window(30, 2'b01, 1'b0, a0, a1, r0, r1);
        check("R10", "pulse after falling bit clock", r0, 1);
        bclk_auto = 1'b1;
    endtask

    initial begin
        t_reset();
        t_passthru();
        t_polarity();
        t_reserved();
        t_strobe_width();
        t_repeat();
        t_active_low();
        t_retrigger();
        t_launch_edge();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule